// File: doc/BRIEF.md
# Selectable-Rate Time-Tag Counter

This block keeps a free-running time-tag count for a serial bus terminal. A 3-bit source code picks what makes the count advance. The count can stand still. It can follow rising edges of an external tick pin, which is asynchronous to the system clock. It can also follow one of six internal tick periods that are derived from the system clock: 2, 4, 8, 16, 32 or 64 microseconds.

The internal periods come from a single phase counter. Its terminal value is computed from the source code and from the number of system-clock cycles per microsecond. Whenever the source code changes or the count is cleared, the phase counter starts again from zero, so the first internal tick after a change always spans a full period. The external pin passes through a two-flop synchronizer, and only rising edges are counted. A synchronous clear strobe zeroes the count and takes priority over any advance in the same cycle.

Top module: `ttag_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, and it stays 0 until an advance occurs after reset.
- R2: With `src_sel` = 3'b000, `count` holds its value at every edge, whatever `ext_tick` does.
- R3: With `src_sel` = 3'b001, `count` increases by one for each rising edge of `ext_tick`. If `ext_tick` rises before clock edge 1, the new value is visible after edge 3.
- R4: With `src_sel` = k for k in 2..7, `count` advances once every `CYCLES_PER_US` × 2^(k-1) clock cycles. With the default of 2 cycles per microsecond, these periods are 4, 8, 16, 32, 64 and 128 cycles.
- R5: When `src_sel` is written with a new internal code at edge E, the first advance happens exactly one full period after E, whatever phase the previous code had reached.
- R6: `count` is `CNT_W` bits wide and wraps from all-ones to zero on the next advance.
- R7: `clr` high at an edge sets `count` to 0 at that edge, even if an advance is due in the same cycle. The internal period restarts from that edge.
- R8: With an internal code (2..7) selected, rising edges on `ext_tick` have no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Increment source: 0 off, 1 external pin, 2..7 internal period of 2^(code-1) us |
| ext_tick | input | 1 | Asynchronous external tick pin |
| clr | input | 1 | Synchronous clear of the count and the internal phase |
| count | output | CNT_W | Current time-tag value |

## Verification
Two situations are the hardest to reach from the ports. The first is the wrap, because with 16 bits and the slowest periods it lies millions of cycles away. The bench therefore builds the counter 10 bits wide and drives it at the fastest internal rate, so that it passes through all-ones within a few thousand cycles. The second is a source change in the middle of a period, where a stale phase would shorten or lengthen the first tick. The bench parks the slower 4 us phase partway through and then switches to the 2 us code, so that the timing of the first advance after the switch shows whether the phase restarted. A clear that lands in the same cycle as a synchronized external edge is arranged by placing the clear strobe exactly at the third edge after the pin rises.

// File: rtl/ttag_pkg.sv
package ttag_pkg;

  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_EXT  = 3'd1,
    SRC_2US  = 3'd2,
    SRC_4US  = 3'd3,
    SRC_8US  = 3'd4,
    SRC_16US = 3'd5,
    SRC_32US = 3'd6,
    SRC_64US = 3'd7
  } src_sel_e;

  // True for the six codes that use the internal prescaler.
  function automatic logic src_is_internal(logic [2:0] s);
    return s >= SRC_2US;
  endfunction

  // Tick period in microseconds: 2^(code-1); zero for non-internal codes.
  function automatic int unsigned period_us(logic [2:0] s);
    if (s < SRC_2US) return 0;
    return 32'd1 << (s - 3'd1);
  endfunction

  // Tick period in system-clock cycles.
  function automatic int unsigned period_cycles(logic [2:0] s, int unsigned cyc_per_us);
    return period_us(s) * cyc_per_us;
  endfunction

endpackage

// File: rtl/ttag_prescaler.sv
module ttag_prescaler
  import ttag_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int unsigned MAX_CYC = CYCLES_PER_US * 64;
  localparam int unsigned PH_W    = $clog2(MAX_CYC);

  logic [2:0]      sel_q;
  logic            sel_chg;
  logic            restart;
  logic            int_mode;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_phase;
  logic            phase_end;

  always_comb begin
    int_mode   = src_is_internal(sel);
    sel_chg    = (sel != sel_q);
    restart    = sel_chg | clr;
    last_phase = int_mode ? PH_W'(period_cycles(sel, CYCLES_PER_US) - 1) : '0;
    phase_end  = (phase_q == last_phase);
    tick       = int_mode & ~restart & phase_end;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SRC_OFF;
    else     sel_q <= sel;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !int_mode) phase_q <= '0;
    else if (phase_end)              phase_q <= '0;
    else                             phase_q <= phase_q + 1'b1;
  end

  // R4: the phase never runs past the terminal value of the selected period
  p_phase_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    (int_mode && !restart) |-> (phase_q <= last_phase));

  // R5: a change of source code restarts the phase
  p_restart_on_change_r5: assert property (@(posedge clk) disable iff (rst)
    sel_chg |=> (phase_q == '0));

  // R7: a clear restarts the phase
  p_restart_on_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase_q == '0));

endmodule

// File: rtl/ttag_ext_sync.sv
module ttag_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R3: one pin edge yields a single-cycle rise pulse
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ttag_count_core.sv
module ttag_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else if (adv)   value <= value + 1'b1;
  end

  // R7: clear wins over advance
  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (value == '0));

  // R6: step is exactly one, wrapping modulo 2^CNT_W
  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && adv) |=> (value == CNT_W'($past(value) + 1'b1)));

  // R2: without an advance the value stays
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(value));

endmodule

// File: rtl/ttag_counter.sv
module ttag_counter
  import ttag_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned CYCLES_PER_US = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       src_sel,
  input  logic             ext_tick,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  logic int_tick;
  logic ext_rise;
  logic advance;

  ttag_prescaler #(.CYCLES_PER_US(CYCLES_PER_US)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .sel  (src_sel),
    .tick (int_tick)
  );

  ttag_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_tick),
    .rise (ext_rise)
  );

  always_comb begin
    if (src_sel == SRC_EXT)             advance = ext_rise;
    else if (src_is_internal(src_sel))  advance = int_tick;
    else                                advance = 1'b0;
  end

  ttag_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .adv   (advance),
    .value (count)
  );

  // R8: an external edge never advances the count while an internal code is selected
  p_ext_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (src_is_internal(src_sel) && ext_rise && !int_tick && !clr) |=> $stable(count));

  // R2: code 000 freezes the count
  p_off_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_OFF && !clr) |=> $stable(count));

endmodule

// File: tb/sim_ttag_counter.sv
`timescale 1ns/1ps
module sim_ttag_counter;
  localparam int CW  = 10;
  localparam int CPU = 2;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    src_sel = 3'd0;
  logic          ext_tick = 1'b0;
  logic          clr = 1'b0;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ttag_counter #(.CNT_W(CW), .CYCLES_PER_US(CPU), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .ext_tick(ext_tick),
    .clr(clr), .count(count)
  );

  function automatic int lim_of(int code);
    return CPU * (1 << (code - 1));
  endfunction

  task automatic check(int got, int exp, string req, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_tick = 1'b1;
    repeat (2) @(negedge clk);
    ext_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Clear together with a code write, then follow `edges` edges (edge 1 is the clear edge).
  task automatic run_internal(int code, int edges, string req);
    int lim;
    lim = lim_of(code);
    @(negedge clk);
    src_sel = 3'(code); clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    check(count, 0, "R7", "count after clear");
    for (int e = 2; e <= edges; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (((e - 1) % lim) == 0 || ((e - 1) % lim) == lim - 1 || e == edges)
        check(count, ((e - 1) / lim) % MOD, req, $sformatf("code %0d edge %0d", code, e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(count, 0, "R1", "count during reset");
    rst = 1'b0;
    @(negedge clk);
    check(count, 0, "R1", "count after reset");

    // R4: every internal period, three periods each
    for (int c = 2; c <= 7; c++) run_internal(c, 3 * lim_of(c) + 2, "R4");

    // R6: wrap through all-ones at the fastest rate
    run_internal(2, MOD * lim_of(2) + 6, "R6");

    // R5: park the 4 us phase mid-period, then switch to 2 us without clearing
    run_internal(3, 6, "R5");
    @(negedge clk) src_sel = 3'd2;
    for (int m = 1; m <= 9; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 4 || m == 5 || m == 8 || m == 9)
        check(count, (m - 1) / 4, "R5", $sformatf("edge %0d after switch", m));
    end

    // R2: hold under code 000 with pin activity, then resume
    run_internal(4, 100, "R4");
    @(negedge clk);
    held = count;
    src_sel = 3'd0;
    for (int p = 0; p < 10; p++) ext_pulse();
    repeat (200) @(negedge clk);
    check(count, held, "R2", "hold with code 000");
    src_sel = 3'd4;
    for (int m = 1; m <= 33; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 16 || m == 17 || m == 33)
        check(count, held + (m - 1) / 16, "R2", $sformatf("resume edge %0d", m));
    end

    // R8: pin edges ignored with an internal code (64 us, 128 cycles)
    @(negedge clk) src_sel = 3'd7; clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    for (int p = 0; p < 20; p++) ext_pulse();
    check(count, 0, "R8", "pin edges under code 111");

    // R3: external edges counted, latency of three edges
    @(negedge clk) src_sel = 3'd1; clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    repeat (4) @(negedge clk);
    check(count, 0, "R3", "no edges yet");
    for (int p = 1; p <= 12; p++) begin
      ext_pulse();
      check(count, p, "R3", $sformatf("after pulse %0d", p));
    end
    ext_tick = 1'b1;
    @(negedge clk);
    check(count, 12, "R3", "latency edge 1");
    @(negedge clk);
    check(count, 12, "R3", "latency edge 2");
    @(negedge clk);
    check(count, 13, "R3", "latency edge 3");
    ext_tick = 1'b0;
    repeat (3) @(negedge clk);

    // R7: clear at the same edge as a synchronized pin edge
    ext_tick = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(count, 0, "R7", "clear beats pin advance");
    repeat (4) @(negedge clk);
    check(count, 0, "R7", "edge consumed by clear");
    ext_tick = 1'b0;

    // R1: reset in the middle of a run
    run_internal(2, 40, "R4");
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check(count, 0, "R1", "mid-run reset");
    rst = 1'b0;
    src_sel = 3'd0;
    repeat (5) @(negedge clk);
    check(count, 0, "R1", "stays zero after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule